// File: doc/BRIEF.md
# Receiver Tuning Parameter Validator

This block keeps three receiver tuning settings in registers: the analog channel bandwidth, the baseband gain and the reference oscillator warp code. It checks each request against the legal range of the target setting before anything is committed. A controller sends a request with a parameter selector, a read/write flag and a binary value. One cycle later the block answers with an acknowledge, or with a refusal and an error code. For reads, the answer also carries the stored value. All three current settings are also driven on parallel output ports at all times, so downstream logic can use them directly.

The set of legal baseband gains depends on the bandwidth currently stored. A narrower filter allows less gain reduction. If a legal bandwidth write leaves the stored gain below the lowest gain allowed for the new bandwidth, the write is still accepted. The gain is then raised to that lowest legal value, and the response carries an informational flag.

Top module: `rx_tune_regs`

## Requirements
- R1: After reset the stored bandwidth is 56000 kHz, the stored gain code is +1 (+6 dB) and the warp code is 2048. No response is pending.
- R2: Every request held on `req_valid` at a clock edge produces exactly one response, with `rsp_valid` high during the following cycle. No response appears without a request.
- R3: A bandwidth write (selector 0) is accepted only for the values 660, 1320, or a multiple of 1000 from 2000 to 56000 inclusive. Any other value is refused with error code 1 and leaves the bandwidth unchanged.
- R4: Gain is a signed count of 6 dB steps. The highest legal code is always +1. The lowest legal code depends on the stored bandwidth: 0 up to 8000 kHz, -1 above 8000 and up to 16000, -2 above 16000 and up to 32000, and -3 above 32000. A gain write (selector 1) outside this range is refused with error code 2 and leaves the gain unchanged.
- R5: A warp write (selector 2) is accepted only for 683 to 3413 inclusive. Any other value is refused with error code 3 and leaves the warp unchanged.
- R6: An accepted bandwidth write whose new lowest gain is above the stored gain sets the gain to that lowest value and raises `rsp_info`. In every other response `rsp_info` is low.
- R7: A read of selectors 0 to 2 is acknowledged with error code 0 and changes nothing. `rsp_data` holds the stored value: bandwidth and warp zero-extended, and gain sign-extended.
- R8: Selector 3, read or write, is refused with error code 4 and changes nothing.
- R9: The parallel read-back ports show a committed change in the same cycle as its acknowledge. A refused request leaves all three settings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_param | input | 2 | Selector: 0 bandwidth, 1 gain, 2 warp, 3 unused |
| req_value | input | 32 | Write value (bandwidth in kHz, gain as signed step code, warp as DAC code) |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_ack | output | 1 | 1 = accepted, 0 = refused |
| rsp_err | output | 3 | Error code, 0 when accepted |
| rsp_info | output | 1 | Gain was raised by a bandwidth change |
| rsp_data | output | 32 | Stored value returned by a read, 0 otherwise |
| cur_bw_khz | output | 16 | Stored bandwidth in kHz |
| cur_gain | output | 3 | Stored gain step code, two's complement |
| cur_warp | output | 12 | Stored warp code |

## Verification
The properties assume that `req_param`, `req_write` and `req_value` are known whenever `req_valid` is high. They also assume the request fields are driven between clock edges, not at them. The properties state invariants on the stored settings (bandwidth in its legal set, gain inside the tier of the stored bandwidth, warp in range). These hold only because every write passes through the checks, so any request pattern is allowed. The stimulus drives all inputs on the falling edge. It includes back-to-back requests, every tier boundary on both sides, and selectors and values chosen at random from sets weighted toward the range edges. The random values are kept as 32-bit integers so that negative and very large values are also exercised.

// File: rtl/rx_tune_pkg.sv
// Package: shared selector and error encodings for the tuning validator.
// Assumes: a 2-bit selector and a 3-bit error field at the block edge.
package rx_tune_pkg;
    typedef enum logic [1:0] {
        PRM_BW   = 2'd0,
        PRM_GAIN = 2'd1,
        PRM_WARP = 2'd2,
        PRM_NONE = 2'd3
    } prm_id_t;

    typedef enum logic [2:0] {
        ERR_OK   = 3'd0,
        ERR_BW   = 3'd1,
        ERR_GAIN = 3'd2,
        ERR_WARP = 3'd3,
        ERR_PRM  = 3'd4
    } err_t;
endpackage

// File: rtl/rxt_bw_rules.sv
// Module: bandwidth rules. Decides whether a kHz value belongs to the legal
// bandwidth set and gives the lowest gain step code allowed at that bandwidth.
// Assumes: value is an unsigned kHz integer; tier limits are ascending.
module rxt_bw_rules #(
    parameter int DATA_W     = 32,
    parameter int GAIN_W     = 3,
    parameter int NARROW_A   = 660,
    parameter int NARROW_B   = 1320,
    parameter int RANGE_LO   = 2000,
    parameter int RANGE_HI   = 56000,
    parameter int RANGE_STEP = 1000,
    parameter int TIER0_MAX  = 8000,
    parameter int TIER1_MAX  = 16000,
    parameter int TIER2_MAX  = 32000
) (
    input  logic [DATA_W-1:0]        value,
    output logic                     legal,
    output logic signed [GAIN_W-1:0] floor_code
);
    localparam logic [DATA_W-1:0] LO_V   = DATA_W'(RANGE_LO);
    localparam logic [DATA_W-1:0] HI_V   = DATA_W'(RANGE_HI);
    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(RANGE_STEP);

    logic in_range;
    logic on_grid;

    // Purpose: membership of the stepped range or one of the two narrow points.
    always_comb begin
        in_range = (value >= LO_V) && (value <= HI_V);
        on_grid  = ((value - LO_V) % STEP_V) == '0;
        legal    = (in_range && on_grid) ||
                   (value == DATA_W'(NARROW_A)) ||
                   (value == DATA_W'(NARROW_B));
    end

    // Purpose: pick the lowest gain code from the bandwidth tier.
    always_comb begin
        if (value <= DATA_W'(TIER0_MAX))      floor_code = GAIN_W'(0);
        else if (value <= DATA_W'(TIER1_MAX)) floor_code = GAIN_W'(-1);
        else if (value <= DATA_W'(TIER2_MAX)) floor_code = GAIN_W'(-2);
        else                                  floor_code = GAIN_W'(-3);
    end
endmodule

// File: rtl/rxt_gain_rules.sv
// Module: gain rules. Checks a signed step code against the window from the
// bandwidth-dependent floor up to a fixed ceiling.
// Assumes: value holds a two's complement integer in DATA_W bits.
module rxt_gain_rules #(
    parameter int DATA_W   = 32,
    parameter int GAIN_W   = 3,
    parameter int GAIN_MAX = 1
) (
    input  logic [DATA_W-1:0]        value,
    input  logic signed [GAIN_W-1:0] floor_code,
    output logic                     legal
);
    logic signed [DATA_W-1:0] val_s;
    logic signed [DATA_W-1:0] floor_s;

    // Purpose: signed window compare at full request width.
    always_comb begin
        val_s   = $signed(value);
        floor_s = DATA_W'(floor_code);
        legal   = (val_s >= floor_s) && (val_s <= DATA_W'(GAIN_MAX));
    end
endmodule

// File: rtl/rxt_warp_rules.sv
// Module: warp rules. Checks an unsigned DAC code against an inclusive window.
// Assumes: value is unsigned; a value above the DAC width is out of range.
module rxt_warp_rules #(
    parameter int DATA_W  = 32,
    parameter int WARP_LO = 683,
    parameter int WARP_HI = 3413
) (
    input  logic [DATA_W-1:0] value,
    output logic              legal
);
    // Purpose: inclusive range compare.
    always_comb begin
        legal = (value >= DATA_W'(WARP_LO)) && (value <= DATA_W'(WARP_HI));
    end
endmodule

// File: rtl/rx_tune_regs.sv
// Module: receiver tuning parameter validator (top). Holds bandwidth, gain and
// warp, validates each request, commits only accepted writes, and answers
// every request one cycle later. A bandwidth write that strands the gain
// below its new floor raises the gain to the floor and flags it.
// Assumes: request fields are known while req_valid is high; no back-pressure.
module rx_tune_regs
    import rx_tune_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int BW_W       = 16,
    parameter int GAIN_W     = 3,
    parameter int WARP_W     = 12,
    parameter int BW_RESET   = 56000,
    parameter int GAIN_RESET = 1,
    parameter int GAIN_MAX   = 1,
    parameter int WARP_RESET = 2048,
    parameter int WARP_LO    = 683,
    parameter int WARP_HI    = 3413
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_param,
    input  logic [DATA_W-1:0]    req_value,
    output logic                 rsp_valid,
    output logic                 rsp_ack,
    output logic [2:0]           rsp_err,
    output logic                 rsp_info,
    output logic [DATA_W-1:0]    rsp_data,
    output logic [BW_W-1:0]      cur_bw_khz,
    output logic [GAIN_W-1:0]    cur_gain,
    output logic [WARP_W-1:0]    cur_warp
);
    localparam int GAIN_EXT = DATA_W - GAIN_W;
    localparam int BW_EXT   = DATA_W - BW_W;
    localparam int WARP_EXT = DATA_W - WARP_W;

    logic                     bw_ok, gain_ok, warp_ok;
    logic signed [GAIN_W-1:0] new_floor, cur_floor;
    logic                     cur_bw_ok;
    logic signed [GAIN_W-1:0] gain_s;

    logic                     n_ack, n_info;
    err_t                     n_err;
    logic [DATA_W-1:0]        n_data;
    logic                     wr_bw, wr_gain, wr_warp, clamp;

    assign gain_s = $signed(cur_gain);

    // Rule checks on the incoming value.
    rxt_bw_rules #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_bw_req (
        .value(req_value), .legal(bw_ok), .floor_code(new_floor));

    // Floor and legality of the currently stored bandwidth.
    rxt_bw_rules #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_bw_cur (
        .value({{BW_EXT{1'b0}}, cur_bw_khz}), .legal(cur_bw_ok),
        .floor_code(cur_floor));

    rxt_gain_rules #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)) u_gain (
        .value(req_value), .floor_code(cur_floor), .legal(gain_ok));

    rxt_warp_rules #(.DATA_W(DATA_W), .WARP_LO(WARP_LO), .WARP_HI(WARP_HI)) u_warp (
        .value(req_value), .legal(warp_ok));

    // Purpose: decode the request into a verdict and commit enables.
    always_comb begin
        n_ack   = 1'b0;
        n_info  = 1'b0;
        n_err   = ERR_OK;
        n_data  = '0;
        wr_bw   = 1'b0;
        wr_gain = 1'b0;
        wr_warp = 1'b0;
        clamp   = 1'b0;
        case (prm_id_t'(req_param))
            PRM_BW: begin
                if (!req_write) begin
                    n_ack  = 1'b1;
                    n_data = {{BW_EXT{1'b0}}, cur_bw_khz};
                end else if (bw_ok) begin
                    n_ack  = 1'b1;
                    wr_bw  = 1'b1;
                    clamp  = gain_s < new_floor;
                    n_info = clamp;
                end else begin
                    n_err = ERR_BW;
                end
            end
            PRM_GAIN: begin
                if (!req_write) begin
                    n_ack  = 1'b1;
                    n_data = {{GAIN_EXT{cur_gain[GAIN_W-1]}}, cur_gain};
                end else if (gain_ok) begin
                    n_ack   = 1'b1;
                    wr_gain = 1'b1;
                end else begin
                    n_err = ERR_GAIN;
                end
            end
            PRM_WARP: begin
                if (!req_write) begin
                    n_ack  = 1'b1;
                    n_data = {{WARP_EXT{1'b0}}, cur_warp};
                end else if (warp_ok) begin
                    n_ack   = 1'b1;
                    wr_warp = 1'b1;
                end else begin
                    n_err = ERR_WARP;
                end
            end
            default: n_err = ERR_PRM;
        endcase
    end

    // Purpose: hold the three settings; commit only accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_bw_khz <= BW_W'(BW_RESET);
            cur_gain   <= GAIN_W'(GAIN_RESET);
            cur_warp   <= WARP_W'(WARP_RESET);
        end else if (req_valid) begin
            if (wr_bw)   cur_bw_khz <= req_value[BW_W-1:0];
            if (clamp)   cur_gain   <= new_floor;
            if (wr_gain) cur_gain   <= req_value[GAIN_W-1:0];
            if (wr_warp) cur_warp   <= req_value[WARP_W-1:0];
        end
    end

    // Purpose: register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ack   <= 1'b0;
            rsp_err   <= ERR_OK;
            rsp_info  <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_ack   <= req_valid & n_ack;
            rsp_err   <= req_valid ? n_err : ERR_OK;
            rsp_info  <= req_valid & n_info;
            rsp_data  <= req_valid ? n_data : '0;
        end
    end

    // Assertions guarding the handshake and the stored-state invariants.
    p_rsp_next_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_bw_stays_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cur_bw_ok);
    p_gain_in_tier_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_s >= cur_floor) && (gain_s <= GAIN_W'(GAIN_MAX)));
    p_warp_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_warp >= WARP_W'(WARP_LO)) && (cur_warp <= WARP_W'(WARP_HI)));
    p_info_with_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_info |-> (rsp_valid && rsp_ack && rsp_err == ERR_OK));
    p_read_keeps_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=>
        ($stable(cur_bw_khz) && $stable(cur_gain) && $stable(cur_warp)));
    p_refusal_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ack) |->
        ($stable(cur_bw_khz) && $stable(cur_gain) && $stable(cur_warp)));
endmodule

// File: tb/rx_tune_regs_tb_top.sv
// Scoreboard bench: the driver task predicts each response from the stated
// rules and queues it; a monitor pops and compares when the response is due.
module rx_tune_regs_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_param = 2'd0;
    logic [31:0] req_value = '0;
    logic        rsp_valid, rsp_ack, rsp_info;
    logic [2:0]  rsp_err;
    logic [31:0] rsp_data;
    logic [15:0] cur_bw_khz;
    logic [2:0]  cur_gain;
    logic [11:0] cur_warp;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_tune_regs dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_param(req_param), .req_value(req_value), .rsp_valid(rsp_valid),
        .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_info(rsp_info),
        .rsp_data(rsp_data), .cur_bw_khz(cur_bw_khz), .cur_gain(cur_gain),
        .cur_warp(cur_warp));

    typedef struct {
        int          due;
        logic        ack;
        logic [2:0]  err;
        logic        info;
        logic [31:0] data;
        int          bw;
        int          gain;
        int          warp;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   cyc     = 0;
    int   m_bw    = 56000;
    int   m_gain  = 1;
    int   m_warp  = 2048;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit bw_legal(logic [31:0] v);
        if (v == 660 || v == 1320) return 1'b1;
        return (v >= 2000 && v <= 56000 && (v % 1000) == 0);
    endfunction

    function automatic int floor_of(int bw);
        if (bw <= 8000)  return 0;
        if (bw <= 16000) return -1;
        if (bw <= 32000) return -2;
        return -3;
    endfunction

    // Driver: drive one request on the falling edge and queue its prediction.
    task automatic send(input bit wr, input logic [1:0] prm,
                        input logic [31:0] val, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_param = prm; req_value = val;
        e.due = cyc + 1; e.ack = 1'b0; e.err = 3'd0; e.info = 1'b0;
        e.data = '0; e.tag = tag;
        if (prm == 2'd3) e.err = 3'd4;
        else if (!wr) begin
            e.ack = 1'b1;
            e.data = (prm == 2'd0) ? 32'(m_bw) : (prm == 2'd1) ? 32'(m_gain) : 32'(m_warp);
        end else if (prm == 2'd0) begin
            if (bw_legal(val)) begin
                e.ack = 1'b1; m_bw = int'(val);
                if (m_gain < floor_of(m_bw)) begin
                    m_gain = floor_of(m_bw); e.info = 1'b1;
                end
            end else e.err = 3'd1;
        end else if (prm == 2'd1) begin
            if ($signed(val) >= floor_of(m_bw) && $signed(val) <= 1) begin
                e.ack = 1'b1; m_gain = $signed(val);
            end else e.err = 3'd2;
        end else begin
            if (val >= 683 && val <= 3413) begin
                e.ack = 1'b1; m_warp = int'(val);
            end else e.err = 3'd3;
        end
        e.bw = m_bw; e.gain = m_gain; e.warp = m_warp;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: compare the response and read-back in the cycle it is due.
    always @(negedge clk) begin
        if (rst_n) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                n_tests++;
                if (rsp_valid !== 1'b1 || rsp_ack !== e.ack || rsp_err !== e.err ||
                    rsp_info !== e.info || rsp_data !== e.data ||
                    int'(cur_bw_khz) != e.bw || int'($signed(cur_gain)) != e.gain ||
                    int'(cur_warp) != e.warp) begin
                    n_fail++;
                    $display("FAIL %s: v/ack/err/info/data/bw/gain/warp act %0b/%0b/%0d/%0b/%0d/%0d/%0d/%0d exp 1/%0b/%0d/%0b/%0d/%0d/%0d/%0d",
                        e.tag, rsp_valid, rsp_ack, rsp_err, rsp_info, $signed(rsp_data),
                        cur_bw_khz, $signed(cur_gain), cur_warp,
                        e.ack, e.err, e.info, $signed(e.data), e.bw, e.gain, e.warp);
                end
            end else if (rsp_valid === 1'b1) begin
                n_tests++; n_fail++;
                $display("FAIL R2: unexpected response act rsp_valid=1 exp 0");
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: act running exp finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        n_tests++;
        if (cur_bw_khz !== 16'd56000 || cur_gain !== 3'd1 || cur_warp !== 12'd2048 ||
            rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: act bw=%0d gain=%0d warp=%0d v=%0b exp 56000/1/2048/0",
                     cur_bw_khz, cur_gain, cur_warp, rsp_valid);
        end
        send(0, 2'd0, 0, "R7 read bw");
        send(0, 2'd1, 0, "R7 read gain");
        send(0, 2'd2, 0, "R7 read warp");
        idle(2);
        send(1, 2'd1, -3, "R4 gain -3 at 56000");
        send(1, 2'd1, 2, "R4 gain +2 refused");
        send(1, 2'd0, 8000, "R6 bw 8000 raises gain");
        send(0, 2'd1, 0, "R7 read raised gain");
        send(1, 2'd1, -1, "R4 gain -1 at 8000 refused");
        send(1, 2'd1, 0, "R4 gain 0 at 8000");
        send(1, 2'd0, 8001, "R3 bw 8001 refused");
        send(1, 2'd0, 660, "R3 bw 660");
        send(1, 2'd0, 1000, "R3 bw 1000 refused");
        send(1, 2'd0, 1320, "R3 bw 1320");
        send(1, 2'd0, 1999, "R3 bw 1999 refused");
        send(1, 2'd0, 57000, "R3 bw 57000 refused");
        send(1, 2'd0, 0, "R3 bw 0 refused");
        send(1, 2'd0, 9000, "R3 bw 9000");
        send(1, 2'd1, -1, "R4 gain -1 at 9000");
        send(1, 2'd0, 16000, "R6 bw 16000 no raise");
        send(1, 2'd1, -2, "R4 gain -2 at 16000 refused");
        send(1, 2'd0, 17000, "R3 bw 17000");
        send(1, 2'd1, -2, "R4 gain -2 at 17000");
        send(1, 2'd0, 32000, "R3 bw 32000");
        send(1, 2'd1, -3, "R4 gain -3 at 32000 refused");
        send(1, 2'd0, 33000, "R3 bw 33000");
        send(1, 2'd1, -3, "R4 gain -3 at 33000");
        send(1, 2'd0, 2000, "R6 bw 2000 raises to 0");
        send(1, 2'd2, 682, "R5 warp 682 refused");
        send(1, 2'd2, 683, "R5 warp 683");
        send(1, 2'd2, 3413, "R5 warp 3413");
        send(1, 2'd2, 3414, "R5 warp 3414 refused");
        send(1, 2'd2, 32'hFFFF_FFFF, "R5 warp huge refused");
        send(1, 2'd3, 1320, "R8 selector 3 write");
        send(0, 2'd3, 0, "R8 selector 3 read");
        send(1, 2'd0, 56000, "R9 bw 56000 back to back");
        idle(3);
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  p;
            logic [31:0] v;
            p = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 3))
                0: v = 32'($urandom_range(0, 60) * 1000);
                1: v = 32'($urandom_range(0, 4)) - 32'd3;
                2: v = 32'($urandom_range(600, 3500));
                default: v = $urandom;
            endcase
            send($urandom_range(0, 3) != 0, p, v, "R9 random mix");
            if ($urandom_range(0, 4) == 0) idle(1);
        end
        idle(3);
        n_tests++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: act %0d responses missing exp 0", q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule